// File: doc/BRIEF.md
# Paced Sample Stream Source

This block is a test data source for a card-to-host streaming DMA channel. It drives a 256-bit AXI4-Stream master port with beats that carry a running sample count, so the host can spot samples that went missing or arrived twice. The stream is cut into packets of a programmable number of beats. The packet length is set to match the byte count of each host read. With the default of 128 beats of 32 bytes, a packet is 4096 bytes. TLAST marks the final beat of each packet. Both TKEEP and TSTRB are driven all-ones, so that any buffer on the path counts every byte as valid.

A throttle keeps the average rate below the full link rate. A new beat may be presented at most once every N clock cycles, where N is the rate divisor. At 250 MHz, N = 32 gives about 250 MB/s and N = 64 gives about 125 MB/s. The block always respects TREADY. Software-facing controls are a level enable, the packet length in beats and the divisor. The only status output is a count of packets that have been fully delivered.

Control is a three-state machine:
- `ST_IDLE`: between packets, TVALID low.
- `ST_HOLD`: a beat is on the bus.
- `ST_PACE`: inside a packet, waiting for the throttle.

The transitions are:
- IDLE→HOLD (start): enable is high and the throttle allows a beat.
- HOLD→HOLD (stream): a beat is accepted and the next one may go at once.
- HOLD→PACE (wait): a non-final beat is accepted but the throttle is not yet open.
- PACE→HOLD (resume): the throttle opens.
- HOLD→IDLE (stop): the final beat is accepted and either enable is low or the throttle is closed.

Top module: `paced_sample_source`

## Requirements
- R1: TDATA is eight 32-bit words. Word j (bits 32j+31:32j) equals 8·s + j modulo 2^32, where s is the number of beats accepted since reset. s advances only on a TVALID&TREADY handshake.
- R2: Whenever TVALID is high, TKEEP and TSTRB are all-ones (32'hFFFF_FFFF).
- R3: TLAST is high on exactly one beat per packet: beat index L−1 counted from 0. L is `cfg_beats`, sampled when the first beat of the packet is launched, and a value of 0 is treated as 1.
- R4: Once TVALID is high, TVALID, TDATA and TLAST stay unchanged until the cycle in which TREADY is high.
- R5: Beat launches are at least N cycles apart, where N is `cfg_divisor` and 0 counts as 1. When TREADY and enable stay high, exactly one beat is launched every N cycles, including across packet boundaries.
- R6: If enable drops in the middle of a packet, the packet still completes through its TLAST beat, and after that TVALID stays low. While enable is low and no packet is open, no beat appears.
- R7: `stat_packets` rises by one for each accepted TLAST beat and is unchanged in every other cycle.
- R8: Synchronous active-high reset drives TVALID low and clears `stat_packets`. The first beat after reset carries s = 0 and starts a new packet at beat index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Start new packets while high |
| cfg_beats | input | 16 | Packet length in beats (0 treated as 1) |
| cfg_divisor | input | 16 | Minimum cycles between beat launches (0 treated as 1) |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 256 | Eight 32-bit sample words |
| m_tkeep | output | 32 | Byte keep, all-ones |
| m_tstrb | output | 32 | Byte strobe, all-ones |
| m_tlast | output | 1 | Final beat of packet |
| stat_packets | output | 32 | Count of accepted TLAST beats |

## Verification
The minimum-gap assertion assumes that `cfg_divisor` does not change while beats are flowing. The length latch assumes that `cfg_beats` is only used at packet starts. The bench changes both only while the source is idle with enable low. TREADY is treated as free-running, so the stimulus drives it three ways: held high, toggling every cycle, and from a pseudo-random bit, always on the falling edge. The sweep covers every combination of lengths 0, 1, 2, 3, 5 and divisors 0 to 4. Each run drops enable in the middle of its last packet and then watches an idle window.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PACE = 2'd1,
        ST_HOLD = 2'd2
    } pss_state_e;

    function automatic logic [15:0] at_least_one(input logic [15:0] v);
        return (v == 16'd0) ? 16'd1 : v;
    endfunction
endpackage

// File: rtl/pss_throttle.sv
module pss_throttle #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             launch,
    output logic             pace_ok
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [DIV_W:0]   SAT = {(DIV_W+1){1'b1}};

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] wait_q;

    assign div_eff = (divisor == '0) ? ONE : divisor;
    assign pace_ok = (wait_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (launch) begin
            wait_q <= div_eff - ONE;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - ONE;
        end
    end

    // Independent gap observer for the minimum spacing check.
    logic [DIV_W:0] since_q;
    logic           seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (launch) begin
            since_q <= (DIV_W+1)'(1);
            seen_q  <= 1'b1;
        end else if (since_q != SAT) begin
            since_q <= since_q + (DIV_W+1)'(1);
        end
    end

    // R5
    min_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (launch && seen_q) |-> (since_q >= {1'b0, div_eff}));
endmodule

// File: rtl/pss_sequencer.sv
module pss_sequencer
    import pss_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [LEN_W-1:0] beats_cfg,
    input  logic             pace_ok,
    input  logic             tready,
    output logic             tvalid,
    output logic             tlast,
    output logic             launch,
    output logic             accept
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    pss_state_e       state_q, state_n;
    logic [LEN_W-1:0] beat_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_eff;
    logic             start;
    logic             at_end;

    assign len_eff = (beats_cfg == '0) ? ONE : beats_cfg;
    assign at_end  = (beat_q == len_q - ONE);

    // next-state and launch decision
    always_comb begin
        state_n = state_q;
        launch  = 1'b0;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && pace_ok) begin
                    launch  = 1'b1;
                    start   = 1'b1;
                    state_n = ST_HOLD;
                end
            end
            ST_PACE: begin
                if (pace_ok) begin
                    launch  = 1'b1;
                    state_n = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tready) begin
                    if (at_end) begin
                        if (enable && pace_ok) begin
                            launch  = 1'b1;
                            start   = 1'b1;
                            state_n = ST_HOLD;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end else if (pace_ok) begin
                        launch  = 1'b1;
                        state_n = ST_HOLD;
                    end else begin
                        state_n = ST_PACE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register and packet position
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            len_q   <= ONE;
        end else begin
            state_q <= state_n;
            if (launch) begin
                if (start) begin
                    beat_q <= '0;
                    len_q  <= len_eff;
                end else begin
                    beat_q <= beat_q + ONE;
                end
            end
        end
    end

    // outputs
    always_comb begin
        tvalid = (state_q == ST_HOLD);
        tlast  = tvalid && at_end;
        accept = tvalid && tready;
    end

    // R4
    hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (tvalid && !tready) |=> (tvalid && $stable(tlast)));

    // R6
    finish_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !tlast) |=> (state_q != ST_IDLE));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !enable) |=> !tvalid);

    // R3
    first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (start) |=> (beat_q == '0));
endmodule

// File: rtl/pss_payload.sv
module pss_payload #(
    parameter int DATA_W = 256,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tvalid,
    input  logic              tready,
    output logic [DATA_W-1:0] tdata
);
    localparam int LANES = DATA_W / WORD_W;
    localparam int SH    = $clog2(LANES);

    logic [WORD_W-1:0] seq_q;
    logic [WORD_W-1:0] base;

    assign base = seq_q << SH;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else if (tvalid && tready) begin
            seq_q <= seq_q + WORD_W'(1);
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign tdata[j*WORD_W +: WORD_W] = base | WORD_W'(j);
    end

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tvalid && !tready) |=> $stable(tdata));
endmodule

// File: rtl/paced_sample_source.sv
module paced_sample_source
    import pss_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16,
    parameter int DIV_W  = 16,
    parameter int STAT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_enable,
    input  logic [LEN_W-1:0]    cfg_beats,
    input  logic [DIV_W-1:0]    cfg_divisor,
    output logic                m_tvalid,
    input  logic                m_tready,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic [DATA_W/8-1:0] m_tstrb,
    output logic                m_tlast,
    output logic [STAT_W-1:0]   stat_packets
);
    localparam int BYTES = DATA_W / 8;

    logic pace_ok;
    logic launch;
    logic accept;
    logic [STAT_W-1:0] pkt_q;

    pss_throttle #(.DIV_W(DIV_W)) u_throttle (
        .clk     (clk),
        .rst     (rst),
        .divisor (cfg_divisor),
        .launch  (launch),
        .pace_ok (pace_ok)
    );

    pss_sequencer #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg_enable),
        .beats_cfg (cfg_beats),
        .pace_ok   (pace_ok),
        .tready    (m_tready),
        .tvalid    (m_tvalid),
        .tlast     (m_tlast),
        .launch    (launch),
        .accept    (accept)
    );

    pss_payload #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_payload (
        .clk    (clk),
        .rst    (rst),
        .tvalid (m_tvalid),
        .tready (m_tready),
        .tdata  (m_tdata)
    );

    assign m_tkeep = {BYTES{1'b1}};
    assign m_tstrb = {BYTES{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_q <= '0;
        end else if (accept && m_tlast) begin
            pkt_q <= pkt_q + STAT_W'(1);
        end
    end

    assign stat_packets = pkt_q;

    // R7
    pkt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && m_tlast) |=> (stat_packets == $past(stat_packets) + STAT_W'(1)));

    // R7
    pkt_flat_chk: assert property (@(posedge clk) disable iff (rst)
        !(m_tvalid && m_tready && m_tlast) |=> $stable(stat_packets));
endmodule

// File: tb/tb_paced_sample_source.sv
module tb_paced_sample_source;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [15:0]  beats = 16'd4;
    logic [15:0]  divv  = 16'd1;
    logic         valid;
    logic         rdy = 1'b0;
    logic [255:0] data;
    logic [31:0]  keep, strb;
    logic         last;
    logic [31:0]  pkts_o;

    paced_sample_source dut (
        .clk(clk), .rst(rst), .cfg_enable(en), .cfg_beats(beats),
        .cfg_divisor(divv), .m_tvalid(valid), .m_tready(rdy),
        .m_tdata(data), .m_tkeep(keep), .m_tstrb(strb), .m_tlast(last),
        .stat_packets(pkts_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0;
    int seq = 0, bip = 0, pkts = 0, hs_total = 0, cyc = 0, last_launch = 0;
    bit have_launch = 0, prev_valid = 0, prev_ready = 0, prev_hs = 0, prev_last = 0;
    logic [255:0] prev_data = '0;
    logic [15:0]  lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] expect_data(input int s);
        logic [255:0] v;
        for (int j = 0; j < 8; j++) v[j*32 +: 32] = 32'(s * 8 + j);
        return v;
    endfunction

    task automatic step(input int mode, input int n_eff, input int len_eff);
        bit launch_now, hs;
        @(negedge clk);
        cyc++;
        case (mode)
            0: rdy = 1'b1;
            1: rdy = ~rdy;
            default: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                rdy  = lfsr[0];
            end
        endcase
        #1;
        if (valid) begin
            chk(keep == '1 && strb == '1, "R2", "keep/strb", {keep, strb}, 64'hFFFFFFFF_FFFFFFFF);
            launch_now = !prev_valid || prev_hs;
            if (!launch_now) begin
                chk(data == prev_data && last == prev_last, "R4", "held beat",
                    data[63:0], prev_data[63:0]);
            end else begin
                if (have_launch) begin
                    if (mode == 0)
                        chk(cyc - last_launch == n_eff, "R5", "gap exact", 64'(cyc - last_launch), 64'(n_eff));
                    else
                        chk(cyc - last_launch >= n_eff, "R5", "gap min", 64'(cyc - last_launch), 64'(n_eff));
                end
                last_launch = cyc;
                have_launch = 1;
            end
        end
        hs = valid && rdy;
        if (hs) begin
            chk(data == expect_data(seq), "R1", "sample words", data[63:0], expect_data(seq)[63:0]);
            chk(last == (bip == len_eff - 1), "R3", "tlast position", 64'(last), 64'(bip == len_eff - 1));
            seq++;
            bip++;
            hs_total++;
            if (bip == len_eff) begin
                bip = 0;
                pkts++;
            end
        end
        prev_valid = valid;
        prev_ready = rdy;
        prev_hs    = hs;
        prev_data  = data;
        prev_last  = last;
    endtask

    task automatic run_cfg(input int len, input int dv, input int mode, input int npk);
        int n_eff, len_eff, base, target, drop, guard;
        n_eff   = (dv == 0) ? 1 : dv;
        len_eff = (len == 0) ? 1 : len;
        beats   = 16'(len);
        divv    = 16'(dv);
        have_launch = 0;
        base   = hs_total;
        target = npk * len_eff;
        drop   = (npk - 1) * len_eff + 1;
        en     = 1'b1;
        guard  = 0;
        while (hs_total - base < target && guard < 20000) begin
            step(mode, n_eff, len_eff);
            if (hs_total - base == drop) en = 1'b0;
            guard++;
        end
        // R6: packet completed after enable dropped, then silence
        chk(hs_total - base == target, "R6", "beats delivered", 64'(hs_total - base), 64'(target));
        chk(bip == 0, "R6", "ended on packet boundary", 64'(bip), 64'd0);
        for (int k = 0; k < 30; k++) begin
            step(mode, n_eff, len_eff);
            if (prev_valid) chk(1'b0, "R6", "valid while disabled", 64'd1, 64'd0);
        end
        checks++;
        chk(pkts_o == 32'(pkts), "R7", "packet count", 64'(pkts_o), 64'(pkts));
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int lens[5] = '{0, 1, 2, 3, 5};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(valid == 1'b0, "R8", "valid in reset", 64'(valid), 64'd0);
        chk(pkts_o == 0, "R8", "count in reset", 64'(pkts_o), 64'd0);
        rst = 1'b0;

        for (int li = 0; li < 5; li++)
            for (int dv = 0; dv <= 4; dv++)
                for (int m = 0; m < 3; m++)
                    run_cfg(lens[li], dv, m, 3);

        // R8: reset in the middle of a packet
        beats = 16'd4;
        divv  = 16'd1;
        en    = 1'b1;
        have_launch = 0;
        for (int k = 0; k < 6; k++) step(0, 1, 4);
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(valid == 1'b0, "R8", "valid after reset", 64'(valid), 64'd0);
        chk(pkts_o == 0, "R8", "count after reset", 64'(pkts_o), 64'd0);
        seq = 0; bip = 0; pkts = 0;
        prev_valid = 0; prev_hs = 0;
        rst = 1'b0;
        run_cfg(2, 1, 0, 2);
        chk(seq == 4, "R8", "samples restart from zero", 64'(seq), 64'd4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule